// File: doc/BRIEF.md
# Byte ALU with Eight-Flag Status Register

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes two operand bytes, a 5-bit operation code and a bit selector, and at once produces a result byte together with a write-enable for that result. The flags the operation produces are merged into an internal 8-bit status register. That register is written at the next rising clock edge, but only when the flag-update strobe is high. The current contents of the status register feed back as the carry-in, the chained zero input and the transfer bit for the next operation. The register is visible on an output port.

The operations are: addition and subtraction, each with and without carry; increment; decrement; two's-complement negation; AND, OR and XOR; bitwise inversion; logical and arithmetic shifts; rotates through carry; nibble exchange; two compares that set flags but write no result; and a pair of operations that move one bit into and out of the transfer flag. Each operation changes only its own set of flags. The others keep their value. Status bit positions: 7 = I, 6 = T (transfer), 5 = H (half carry), 4 = S (sign), 3 = V (overflow), 2 = N (negative), 1 = Z (zero), 0 = C (carry/borrow). In the requirements, r is the result, a is op_a, b is op_b, and Cin, Zin and Tin are the status bits held before the operation.

Top module: `alu8_core`

## Requirements
- R1: Synchronous active-high reset clears all eight status bits to 0. The status register changes only on a rising clock edge.
- R2: Code 0 (add) gives r = a+b and code 1 (add with carry) gives r = a+b+Cin, each modulo 256. C is the carry out of bit 7, H is the carry from bit 3 into bit 4, V is signed overflow, N = r[7], Z = (r == 0). The result is written.
- R3: Code 2 (subtract) gives r = a−b and code 3 (subtract with borrow) gives r = a−b−Cin. Code 6 (negate) gives r = 0−a. C is the borrow out of bit 7, H is the borrow out of bit 3, V is signed overflow, N = r[7]. The result is written.
- R4: For codes 3 and 18 the new Z is (r == 0) AND Zin. A nonzero result clears Z, and a zero result never sets Z.
- R5: Code 17 (compare) and code 18 (compare with borrow) set H, S, V, N, Z and C exactly as codes 2 and 3 would, and hold result_we low.
- R6: Code 4 (increment, r = a+1) and code 5 (decrement, r = a−1) update S, V, N and Z and leave C and H unchanged. V is set for a = 0x7F on increment and for a = 0x80 on decrement.
- R7: Codes 7, 8 and 9 (AND, OR, XOR with b) clear V, set N and Z from r, and leave C and H unchanged. Code 10 (invert, r = 0xFF−a) does the same but also sets C to 1.
- R8: Code 11 (shift left) puts a[7] in C, a[3] in H and 0 in r[0]. Code 12 (logical shift right) puts a[0] in C and 0 in r[7]. Code 13 (arithmetic shift right) puts a[0] in C and keeps a[7]. For all three, V = N XOR C.
- R9: Code 14 rotates left through carry (r[0] = Cin, C = a[7], H = a[3]). Code 15 rotates right through carry (r[7] = Cin, C = a[0]). For both, V = N XOR C. Code 16 exchanges the two nibbles of a and changes no flag.
- R10: Code 19 copies a[bit_sel] into T, writes no result and changes no other flag. Code 20 returns a with bit bit_sel replaced by Tin, writes the result and changes no flag.
- R11: After every update, S equals N XOR V.
- R12: When flag_we is low the status register holds its value. Status bit 7 never changes after reset. Codes 21 to 31 write no result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand byte |
| op_b | input | 8 | Second operand byte |
| opcode | input | 5 | Operation code (see requirements) |
| bit_sel | input | 3 | Bit index for the transfer-bit operations |
| flag_we | input | 1 | Strobe that loads the merged flags into the status register |
| result | output | 8 | Combinational result byte |
| result_we | output | 1 | High when the operation writes its result |
| status | output | 8 | Registered status register |

## Verification
The case that is hardest to reach from the ports is the chained zero flag. Z must already be set before a borrow-chained subtract or compare runs, and the carry must hold the right value. Only the preceding operations can arrange this, because the status register has no direct load path. The bench sweeps every operation code over all 256 values of op_a against edge-heavy op_b values and leaves the status register running through the whole sweep, so each vector starts from whatever flags earlier vectors left behind. A directed two-byte compare sequence then covers the equal, low-byte-different and high-byte-different cases on their own.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 5;
    localparam int BSW = $clog2(DW);

    // status bit positions (other logic decodes these)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    localparam logic [DW-1:0] M_C = DW'(1) << F_C;
    localparam logic [DW-1:0] M_Z = DW'(1) << F_Z;
    localparam logic [DW-1:0] M_N = DW'(1) << F_N;
    localparam logic [DW-1:0] M_V = DW'(1) << F_V;
    localparam logic [DW-1:0] M_S = DW'(1) << F_S;
    localparam logic [DW-1:0] M_H = DW'(1) << F_H;
    localparam logic [DW-1:0] M_T = DW'(1) << F_T;
    localparam logic [DW-1:0] M_I = DW'(1) << F_I;

    localparam logic [DW-1:0] M_SVNZ   = M_S | M_V | M_N | M_Z;
    localparam logic [DW-1:0] M_SVNZC  = M_SVNZ | M_C;
    localparam logic [DW-1:0] M_HSVNZC = M_SVNZC | M_H;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 5'd0,
        OP_ADDC   = 5'd1,
        OP_SUB    = 5'd2,
        OP_SUBB   = 5'd3,
        OP_INCR   = 5'd4,
        OP_DECR   = 5'd5,
        OP_NEGATE = 5'd6,
        OP_AND    = 5'd7,
        OP_OR     = 5'd8,
        OP_XOR    = 5'd9,
        OP_INVERT = 5'd10,
        OP_SHL    = 5'd11,
        OP_SHR    = 5'd12,
        OP_SAR    = 5'd13,
        OP_RCL    = 5'd14,
        OP_RCR    = 5'd15,
        OP_NSWAP  = 5'd16,
        OP_CMP    = 5'd17,
        OP_CMPB   = 5'd18,
        OP_TSTORE = 5'd19,
        OP_TLOAD  = 5'd20
    } op_e;

    typedef struct packed {
        logic [DW-1:0] value;  // result byte
        logic [DW-1:0] flags;  // candidate flag values
        logic [DW-1:0] touch;  // which flags this operation owns
        logic          wr;     // result write-enable
    } unit_out_t;

    function automatic logic all_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_flag,
    input  logic          z_flag,
    output logic          hit,
    output unit_out_t     o
);

    logic [DW-1:0] x, y, ey, r;
    logic          cin, sub, chain, wr, ec, co;
    logic [DW-1:0] touch;
    logic [NIB:0]  lo;
    logic          cf, hf, vf, nf, zf;

    // operand steering: every member shares one adder
    always_comb begin
        x     = a;
        y     = b;
        cin   = 1'b0;
        sub   = 1'b0;
        chain = 1'b0;
        wr    = 1'b1;
        hit   = 1'b1;
        touch = M_HSVNZC;
        case (op)
            OP_ADD:    ;
            OP_ADDC:   cin = c_flag;
            OP_SUB:    sub = 1'b1;
            OP_SUBB:   begin sub = 1'b1; cin = c_flag; chain = 1'b1; end
            OP_CMP:    begin sub = 1'b1; wr = 1'b0; end
            OP_CMPB:   begin sub = 1'b1; cin = c_flag; chain = 1'b1; wr = 1'b0; end
            OP_INCR:   begin y = DW'(1); touch = M_SVNZ; end
            OP_DECR:   begin y = DW'(1); sub = 1'b1; touch = M_SVNZ; end
            OP_NEGATE: begin x = '0; y = a; sub = 1'b1; end
            OP_SHL:    y = a;
            OP_RCL:    begin y = a; cin = c_flag; end
            default:   begin hit = 1'b0; wr = 1'b0; touch = '0; end
        endcase
    end

    // subtraction as x + ~y + ~borrow_in
    assign ey = sub ? ~y : y;
    assign ec = sub ? ~cin : cin;
    assign {co, r} = {1'b0, x} + {1'b0, ey} + {{DW{1'b0}}, ec};
    assign lo      = {1'b0, x[NIB-1:0]} + {1'b0, ey[NIB-1:0]} + {{NIB{1'b0}}, ec};

    assign cf = co ^ sub;
    assign hf = lo[NIB] ^ sub;
    assign vf = (x[DW-1] ~^ ey[DW-1]) & (r[DW-1] ^ x[DW-1]);
    assign nf = r[DW-1];
    assign zf = all_zero(r) & (chain ? z_flag : 1'b1);

    always_comb begin
        o.value        = r;
        o.flags        = '0;
        o.flags[F_C]   = cf;
        o.flags[F_Z]   = zf;
        o.flags[F_N]   = nf;
        o.flags[F_V]   = vf;
        o.flags[F_S]   = nf ^ vf;
        o.flags[F_H]   = hf;
        o.touch        = touch;
        o.wr           = wr;
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  op_e            op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [BSW-1:0] bit_sel,
    input  logic           c_flag,
    input  logic           t_flag,
    output logic           hit,
    output unit_out_t      o
);

    typedef enum logic [1:0] {V_CLEAR, V_NXORC} vrule_e;

    logic [DW-1:0] r;
    logic [DW-1:0] touch;
    logic          cf, tf, wr, nf, vf;
    vrule_e        vrule;

    always_comb begin
        r     = a;
        cf    = 1'b0;
        tf    = 1'b0;
        wr    = 1'b1;
        hit   = 1'b1;
        vrule = V_CLEAR;
        touch = M_SVNZ;
        case (op)
            OP_AND:    r = a & b;
            OP_OR:     r = a | b;
            OP_XOR:    r = a ^ b;
            OP_INVERT: begin r = ~a; cf = 1'b1; touch = M_SVNZC; end
            OP_SHR:    begin r = {1'b0, a[DW-1:1]};     cf = a[0]; vrule = V_NXORC; touch = M_SVNZC; end
            OP_SAR:    begin r = {a[DW-1], a[DW-1:1]};  cf = a[0]; vrule = V_NXORC; touch = M_SVNZC; end
            OP_RCR:    begin r = {c_flag, a[DW-1:1]};   cf = a[0]; vrule = V_NXORC; touch = M_SVNZC; end
            OP_NSWAP:  begin r = {a[NIB-1:0], a[DW-1:NIB]}; touch = '0; end
            OP_TSTORE: begin tf = a[bit_sel]; wr = 1'b0; touch = M_T; end
            OP_TLOAD:  begin r[bit_sel] = t_flag; touch = '0; end
            default:   begin hit = 1'b0; wr = 1'b0; touch = '0; end
        endcase
    end

    assign nf = r[DW-1];
    assign vf = (vrule == V_NXORC) ? (nf ^ cf) : 1'b0;

    always_comb begin
        o.value      = r;
        o.flags      = '0;
        o.flags[F_C] = cf;
        o.flags[F_Z] = all_zero(r);
        o.flags[F_N] = nf;
        o.flags[F_V] = vf;
        o.flags[F_S] = nf ^ vf;
        o.flags[F_T] = tf;
        o.touch      = touch;
        o.wr         = wr;
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [DW-1:0] cand,
    input  logic [DW-1:0] touch,
    output logic [DW-1:0] q
);

    localparam logic [DW-1:0] WRITABLE = ~M_I;

    logic [DW-1:0] own;
    logic [DW-1:0] nxt;

    assign own = touch & WRITABLE;
    assign nxt = (q & ~own) | (cand & own);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (upd)
            q <= nxt;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  logic [OPW-1:0]  opcode,
    input  logic [BSW-1:0]  bit_sel,
    input  logic            flag_we,
    output logic [DW-1:0]   result,
    output logic            result_we,
    output logic [DW-1:0]   status
);

    op_e       op;
    logic      ar_hit, bo_hit;
    unit_out_t ar_o, bo_o, sel_o;

    assign op = op_e'(opcode);

    alu8_arith u_arith (
        .op     (op),
        .a      (op_a),
        .b      (op_b),
        .c_flag (status[F_C]),
        .z_flag (status[F_Z]),
        .hit    (ar_hit),
        .o      (ar_o)
    );

    alu8_bitops u_bitops (
        .op      (op),
        .a       (op_a),
        .b       (op_b),
        .bit_sel (bit_sel),
        .c_flag  (status[F_C]),
        .t_flag  (status[F_T]),
        .hit     (bo_hit),
        .o       (bo_o)
    );

    always_comb begin
        if (ar_hit)
            sel_o = ar_o;
        else if (bo_hit)
            sel_o = bo_o;
        else begin
            sel_o.value = op_a;
            sel_o.flags = '0;
            sel_o.touch = '0;
            sel_o.wr    = 1'b0;
        end
    end

    alu8_status u_status (
        .clk   (clk),
        .rst   (rst),
        .upd   (flag_we),
        .cand  (sel_o.flags),
        .touch (sel_o.touch),
        .q     (status)
    );

    assign result    = sel_o.value;
    assign result_we = sel_o.wr;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [OPW-1:0]  opcode,
    input logic            flag_we,
    input logic            result_we,
    input logic [DW-1:0]   status
);

    assert_ibit_held_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(status[F_I]));

    assert_hold_no_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(status));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_CMP || opcode == OP_CMPB) |-> !result_we);

    assert_sign_rel_R11: assert property (@(posedge clk) disable iff (rst)
        status[F_S] == (status[F_N] ^ status[F_V]));

    assert_zero_chain_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (opcode == OP_SUBB || opcode == OP_CMPB) && !status[F_Z]) |=> !status[F_Z]);

    assert_swap_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_NSWAP) |=> $stable(status));

    assert_tstore_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_TSTORE) |-> !result_we);

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .flag_we   (flag_we),
    .result_we (result_we),
    .status    (status)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] op_a, op_b;
    logic [4:0] opcode;
    logic [2:0] bit_sel;
    logic       flag_we;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_st;

    always #10 clk = ~clk;

    alu8_core u0 (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .opcode    (opcode),
        .bit_sel   (bit_sel),
        .flag_we   (flag_we),
        .result    (result),
        .result_we (result_we),
        .status    (status)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h st=%0h)",
                     tag, act, exp, opcode, op_a, op_b, model_st);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0, 1:           return "R2";
            2, 3, 6:        return "R3/R4";
            17, 18:         return "R5";
            4, 5:           return "R6";
            7, 8, 9, 10:    return "R7";
            11, 12, 13:     return "R8";
            14, 15, 16:     return "R9";
            19, 20:         return "R10";
            default:        return "R12";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic logic [7:0] nzs(input logic [7:0] st, input int r);
        logic [7:0] o;
        o = st;
        o[2] = (r >= 128);
        o[1] = (r == 0);
        o[4] = o[2] ^ o[3];
        return o;
    endfunction

    // reference model built from the requirement text
    task automatic predict(input int op, input int a, input int b, input int bs,
                           input logic [7:0] cur,
                           output int r, output int we, output logic [7:0] st);
        int c, s, sr;
        c  = int'(cur[0]);
        st = cur;
        we = 1;
        r  = a;
        case (op)
            0, 1: begin
                if (op == 0) c = 0;
                s = a + b + c; r = s & 255;
                st[0] = (s > 255);
                st[5] = ((a & 15) + (b & 15) + c) > 15;
                sr = sgn(a) + sgn(b) + c;
                st[3] = (sr > 127) || (sr < -128);
                st = nzs(st, r);
            end
            2, 3, 17, 18: begin
                if (op == 2 || op == 17) c = 0;
                s = a - b - c; r = s & 255;
                st[0] = (s < 0);
                st[5] = ((a & 15) - (b & 15) - c) < 0;
                sr = sgn(a) - sgn(b) - c;
                st[3] = (sr > 127) || (sr < -128);
                st = nzs(st, r);
                if (op == 3 || op == 18) st[1] = (r == 0) && cur[1];
                we = (op == 2 || op == 3) ? 1 : 0;
            end
            4: begin r = (a + 1) & 255; st[3] = (a == 127); st = nzs(st, r); end
            5: begin r = (a + 255) & 255; st[3] = (a == 128); st = nzs(st, r); end
            6: begin
                r = (256 - a) & 255;
                st[0] = (a != 0); st[5] = ((a & 15) != 0); st[3] = (a == 128);
                st = nzs(st, r);
            end
            7:  begin r = a & b; st[3] = 0; st = nzs(st, r); end
            8:  begin r = a | b; st[3] = 0; st = nzs(st, r); end
            9:  begin r = a ^ b; st[3] = 0; st = nzs(st, r); end
            10: begin r = 255 - a; st[3] = 0; st[0] = 1; st = nzs(st, r); end
            11, 14: begin
                r = (a * 2 + ((op == 14) ? c : 0)) & 255;
                st[0] = (a >= 128); st[5] = (((a >> 3) & 1) == 1);
                st[3] = (r >= 128) ^ st[0];
                st = nzs(st, r);
            end
            12, 13, 15: begin
                r = a / 2;
                if (op == 13) r = r + (a & 128);
                if (op == 15) r = r + c * 128;
                st[0] = ((a & 1) == 1);
                st[3] = (r >= 128) ^ st[0];
                st = nzs(st, r);
            end
            16: r = ((a & 15) * 16) + (a / 16);
            19: begin we = 0; st[6] = (((a >> bs) & 1) == 1); end
            20: r = (a & ~(1 << bs) & 255) | (int'(cur[6]) << bs);
            default: we = 0;
        endcase
    endtask

    // one vector: drive after the falling edge, check outputs, then status after the rising edge
    task automatic apply(input int op, input int a, input int b, input int bs, input logic fwe);
        int er, ewe;
        logic [7:0] est;
        @(negedge clk);
        opcode  = 5'(op);
        op_a    = 8'(a);
        op_b    = 8'(b);
        bit_sel = 3'(bs);
        flag_we = fwe;
        predict(op, a, b, bs, model_st, er, ewe, est);
        #3;
        check({req_of(op), " result_we"}, int'(result_we), ewe);
        if (ewe == 1) check({req_of(op), " result"}, int'(result), er);
        @(posedge clk);
        #2;
        if (fwe) model_st = est;
        check({fwe ? req_of(op) : "R12", " status"}, int'(status), int'(model_st));
    endtask

    function automatic int bpick(input int k);
        case (k)
            1:       return 8'h01;
            2:       return 8'h7F;
            3:       return 8'h80;
            4:       return 8'h0F;
            5:       return 8'hF0;
            default: return (k * 17) & 255;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_a = '0; op_b = '0; opcode = '0; bit_sel = '0; flag_we = 1'b0;
        model_st = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset status", int'(status), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: without a strobe nothing moves
        apply(2, 0, 1, 0, 1'b0);
        check("R1 status still clear", int'(status), 0);

        // R4: two-byte compare chains (low byte first)
        apply(0, 0, 0, 0, 1'b1);          // Z=1, C=0
        apply(17, 8'h34, 8'h34, 0, 1'b1); // low bytes equal
        apply(18, 8'h12, 8'h12, 0, 1'b1); // high bytes equal
        check("R4 equal words give Z", int'(status[1]), 1);
        apply(17, 8'h35, 8'h34, 0, 1'b1); // low differ
        apply(18, 8'h12, 8'h12, 0, 1'b1); // high equal, zero result but Z stays clear
        check("R4 low-differ keeps Z clear", int'(status[1]), 0);
        apply(17, 8'h34, 8'h34, 0, 1'b1);
        apply(18, 8'h13, 8'h12, 0, 1'b1);
        check("R4 high-differ clears Z", int'(status[1]), 0);

        // R10: transfer bit round trip
        apply(19, 8'h20, 0, 5, 1'b1);
        check("R10 T set from bit 5", int'(status[6]), 1);
        apply(20, 8'h00, 0, 2, 1'b1);
        check("R10 T loaded into bit 2", int'(result), 8'h04);

        // sweep: every code, all first operands, edge-heavy second operands
        for (int op = 0; op < 24; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    apply(op, a, bpick(k), (a + k) & 7, ((a + k) % 7) != 0);
                end
            end
        end

        // R12: status bit 7 never set
        check("R12 bit 7 held", int'(status[7]), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule